// File: doc/BRIEF.md
# Demand-Weighted Skip Round-Robin Arbiter

This arbiter decides, on every clock cycle, which one of `NPORT` requesters may use a single shared wide memory port. Time is split into loops of `NPORT` cycles, one slot per cycle. In skip mode the grant rotates among the ports that are requesting and passes over idle ports, so no slot is spent on a port with nothing to move.

In weighted mode each port receives a slot quota for the loop. The quota comes from how many bytes the port moved over the most recent `HIST` completed loops. Every port with traffic in that window gets one slot first. The slots that are left then go, one at a time, to the port whose share is still furthest above its slots so far. Shares are compared with integer cross-products, so the block has no divider. A new quota is computed at the end of each loop and takes effect from the first cycle of the next loop. When the window holds no traffic at all, the arbiter runs as a plain skip rotation.

Top module: `demand_skip_arb`

## Requirements
- R1: `gnt_o` has at most one bit set in any cycle, and a bit is set only for a port whose `req_i` bit is set in that same cycle.
- R2: In skip rotation the grant goes to the first requesting port found by searching upward from the port after the last granted one, wrapping from `NPORT-1` to 0. Example: with only ports 0 and 2 requesting, the grants run 0, 2, 0, 2.
- R3: Whenever any `req_i` bit is set, some port is granted in that cycle (no slot is wasted while there is demand).
- R4: A loop is `NPORT` cycles long, and the first cycle after reset is its slot 0. Port i's window total is the sum of its `bytes_i[i*BYTE_W +: BYTE_W]` over the last `HIST` completed loops, and the final cycle of the loop is included. Bytes older than that window have no effect.
- R5: Every port with a nonzero window total gets at least one slot. When any total is nonzero, the slots in `sched_o` add up to exactly `NPORT`.
- R6: After the first slots are given out, each remaining slot goes to the port with a nonzero total S_i that has the largest residual S_i*NPORT - a_i*T. Here a_i is the port's slots so far and T is the sum of all totals. Ties go to the lowest port index.
- R7: In weighted mode (`mode_i`=1 and a nonzero schedule in force), the grant follows the R2 search among requesting ports that still have unused slots in this loop. If no requesting port has an unused slot, the grant follows R2 among all requesters. Each weighted grant uses up one of the port's slots.
- R8: `sched_o` holds port i's slot count in bits `[i*CNT_W +: CNT_W]`, with `CNT_W = $clog2(NPORT+1)`. It changes only on the clock edge that ends a loop.
- R9: When all window totals are zero, `sched_o` is all zero and grants follow R2 even when `mode_i`=1.
- R10: A port with a larger window total never receives fewer slots than a port with a smaller one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| mode_i | input | 1 | 0 = skip rotation, 1 = weighted slots |
| req_i | input | NPORT | Per-port request: the port has data to transfer |
| bytes_i | input | NPORT*BYTE_W | Per-port bytes moved this cycle |
| gnt_o | output | NPORT | One-hot grant for the current cycle |
| sched_o | output | NPORT*CNT_W | Slot counts in force for the current loop |

## Verification
The embedded properties check four things on every cycle: grant exclusivity, grants only to requesters, work conservation, and the preference for credited requesters. They also check that the schedule moves only at a loop edge, that the slots add up to `NPORT`, and that any port with window traffic ends up with a slot. The exact largest-residual outcome, the tie order, the ordering between ports, the expiry of history after `HIST` loops, and the full rotation sequence depend on many cycles of traffic. Only the bench scenarios show these, by comparing each cycle with an arithmetic reference over directed and long pseudo-random traffic.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  typedef enum logic [0:0] {
    ARB_SKIP     = 1'b0,
    ARB_WEIGHTED = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/dsa_traffic_hist.sv
module dsa_traffic_hist #(
  parameter int NPORT  = 4,
  parameter int BYTE_W = 4,
  parameter int HIST   = 2,
  parameter int SUM_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    loop_end_i,
  input  logic [NPORT*BYTE_W-1:0] bytes_i,
  output logic [NPORT*SUM_W-1:0]  win_o
);
  localparam int HDEPTH = (HIST > 1) ? HIST - 1 : 1;

  logic [SUM_W-1:0] acc_q  [NPORT];
  logic [SUM_W-1:0] acc_nx [NPORT];
  logic [SUM_W-1:0] acc_d  [NPORT];
  logic [SUM_W-1:0] hist_q [HDEPTH][NPORT];
  logic [SUM_W-1:0] hist_d [HDEPTH][NPORT];
  logic [SUM_W-1:0] win    [NPORT];

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      acc_nx[i] = acc_q[i] + SUM_W'(bytes_i[i*BYTE_W +: BYTE_W]);
      win[i]    = acc_nx[i];
      for (int j = 0; j < HIST - 1; j++) begin
        win[i] = win[i] + hist_q[j][i];
      end
      acc_d[i] = loop_end_i ? '0 : acc_nx[i];
      for (int j = 0; j < HDEPTH; j++) begin
        hist_d[j][i] = hist_q[j][i];
      end
      if (loop_end_i) begin
        hist_d[0][i] = acc_nx[i];
        for (int j = 1; j < HDEPTH; j++) begin
          hist_d[j][i] = hist_q[j-1][i];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPORT; i++) begin
        acc_q[i] <= '0;
        for (int j = 0; j < HDEPTH; j++) begin
          hist_q[j][i] <= '0;
        end
      end
    end else begin
      for (int i = 0; i < NPORT; i++) begin
        acc_q[i] <= acc_d[i];
        for (int j = 0; j < HDEPTH; j++) begin
          hist_q[j][i] <= hist_d[j][i];
        end
      end
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_win
    assign win_o[g*SUM_W +: SUM_W] = win[g];
  end
endmodule

// File: rtl/dsa_slot_alloc.sv
module dsa_slot_alloc #(
  parameter int NPORT = 4,
  parameter int SUM_W = 8,
  parameter int CNT_W = 3,
  parameter int TOT_W = 11
) (
  input  logic [NPORT*SUM_W-1:0] win_i,
  output logic [NPORT*CNT_W-1:0] alloc_o,
  output logic                   any_o
);
  localparam int PROD_W = TOT_W + CNT_W + 2;
  localparam int PTR_W  = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [SUM_W-1:0]         w [NPORT];
  logic [CNT_W-1:0]         a [NPORT];
  logic [TOT_W-1:0]         tot;
  logic [CNT_W-1:0]         nact;
  logic [PTR_W-1:0]         best;
  logic                     found;
  logic signed [PROD_W-1:0] bval;
  logic signed [PROD_W-1:0] rcur;

  for (genvar g = 0; g < NPORT; g++) begin : g_io
    assign w[g] = win_i[g*SUM_W +: SUM_W];
    assign alloc_o[g*CNT_W +: CNT_W] = a[g];
  end

  always_comb begin
    tot  = '0;
    nact = '0;
    for (int i = 0; i < NPORT; i++) begin
      tot = tot + TOT_W'(w[i]);
      if (w[i] != '0) begin
        a[i] = CNT_W'(1);
        nact = nact + CNT_W'(1);
      end else begin
        a[i] = '0;
      end
    end
    best  = '0;
    found = 1'b0;
    bval  = '0;
    rcur  = '0;
    for (int s = 0; s < NPORT - 1; s++) begin
      if (nact != '0 && CNT_W'(s) < CNT_W'(NPORT) - nact) begin
        found = 1'b0;
        best  = '0;
        bval  = '0;
        for (int i = 0; i < NPORT; i++) begin
          if (w[i] != '0) begin
            rcur = $signed(PROD_W'(w[i]) * PROD_W'(NPORT))
                 - $signed(PROD_W'(a[i]) * PROD_W'(tot));
            if (!found || rcur > bval) begin
              found = 1'b1;
              bval  = rcur;
              best  = PTR_W'(i);
            end
          end
        end
        a[best] = a[best] + CNT_W'(1);
      end
    end
  end

  assign any_o = (tot != '0);
endmodule

// File: rtl/dsa_rr_pick.sv
module dsa_rr_pick #(
  parameter int NPORT = 4,
  parameter int PTR_W = 2
) (
  input  logic [NPORT-1:0] elig_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic [NPORT-1:0] gnt_o,
  output logic [PTR_W-1:0] idx_o,
  output logic             hit_o
);
  int pos;

  always_comb begin
    idx_o = '0;
    hit_o = 1'b0;
    pos   = 0;
    for (int off = NPORT - 1; off >= 0; off--) begin
      pos = int'(ptr_i) + off;
      if (pos >= NPORT) pos = pos - NPORT;
      if (elig_i[pos]) begin
        idx_o = PTR_W'(pos);
        hit_o = 1'b1;
      end
    end
  end

  always_comb begin
    gnt_o = '0;
    if (hit_o) gnt_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/demand_skip_arb.sv
module demand_skip_arb #(
  parameter int NPORT  = 4,
  parameter int BYTE_W = 4,
  parameter int HIST   = 2,
  parameter int CNT_W  = $clog2(NPORT + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mode_i,
  input  logic [NPORT-1:0]        req_i,
  input  logic [NPORT*BYTE_W-1:0] bytes_i,
  output logic [NPORT-1:0]        gnt_o,
  output logic [NPORT*CNT_W-1:0]  sched_o
);
  import dsa_pkg::*;

  localparam int PTR_W = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int SUM_W = BYTE_W + $clog2(NPORT * HIST + 1);
  localparam int TOT_W = SUM_W + $clog2(NPORT + 1);

  // reset synchronizer: asserts at once, releases on the clock
  logic rst_meta_q, rst_n_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  logic [PTR_W-1:0]       slot_q, slot_d, ptr_q, ptr_d, idx;
  logic [CNT_W-1:0]       credit_q [NPORT];
  logic [CNT_W-1:0]       credit_d [NPORT];
  logic [CNT_W-1:0]       new_a    [NPORT];
  logic [NPORT*CNT_W-1:0] sched_q, sched_d, alloc_bus;
  logic                   valid_q, valid_d, any_w, hit, use_w, loop_end;
  logic [NPORT-1:0]       cred_nz, celig, elig;
  logic [NPORT*SUM_W-1:0] win_bus;
  arb_mode_e              mode;

  assign mode     = arb_mode_e'(mode_i);
  assign loop_end = (slot_q == PTR_W'(NPORT - 1));
  assign use_w    = (mode == ARB_WEIGHTED) && valid_q;

  dsa_traffic_hist #(
    .NPORT(NPORT), .BYTE_W(BYTE_W), .HIST(HIST), .SUM_W(SUM_W)
  ) hist_i (
    .clk_i(clk_i), .rst_ni(rst_n_q), .loop_end_i(loop_end),
    .bytes_i(bytes_i), .win_o(win_bus)
  );

  dsa_slot_alloc #(
    .NPORT(NPORT), .SUM_W(SUM_W), .CNT_W(CNT_W), .TOT_W(TOT_W)
  ) alloc_i (
    .win_i(win_bus), .alloc_o(alloc_bus), .any_o(any_w)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_cred
    assign new_a[g]   = alloc_bus[g*CNT_W +: CNT_W];
    assign cred_nz[g] = (credit_q[g] != '0);
  end

  assign celig = req_i & cred_nz;
  assign elig  = (use_w && (celig != '0)) ? celig : req_i;

  dsa_rr_pick #(.NPORT(NPORT), .PTR_W(PTR_W)) pick_i (
    .elig_i(elig), .ptr_i(ptr_q), .gnt_o(gnt_o), .idx_o(idx), .hit_o(hit)
  );

  always_comb begin
    slot_d  = loop_end ? '0 : slot_q + PTR_W'(1);
    ptr_d   = ptr_q;
    if (hit) ptr_d = (idx == PTR_W'(NPORT - 1)) ? '0 : idx + PTR_W'(1);
    for (int i = 0; i < NPORT; i++) credit_d[i] = credit_q[i];
    if (loop_end) begin
      for (int i = 0; i < NPORT; i++) credit_d[i] = new_a[i];
    end else if (hit && use_w && credit_q[idx] != '0) begin
      credit_d[idx] = credit_q[idx] - CNT_W'(1);
    end
    sched_d = loop_end ? alloc_bus : sched_q;
    valid_d = loop_end ? any_w : valid_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      slot_q  <= '0;
      ptr_q   <= '0;
      sched_q <= '0;
      valid_q <= 1'b0;
      for (int i = 0; i < NPORT; i++) credit_q[i] <= '0;
    end else begin
      slot_q <= slot_d;
      ptr_q  <= ptr_d;
      for (int i = 0; i < NPORT; i++) credit_q[i] <= credit_d[i];
      if (loop_end) begin
        sched_q <= sched_d;
        valid_q <= valid_d;
      end
    end
  end

  assign sched_o = sched_q;

  // ---------------- assertions ----------------
  logic [CNT_W+PTR_W:0] sched_sum;
  always_comb begin
    sched_sum = '0;
    for (int i = 0; i < NPORT; i++)
      sched_sum = sched_sum + (CNT_W+PTR_W+1)'(sched_q[i*CNT_W +: CNT_W]);
  end

  p_gnt_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    $onehot0(gnt_o));
  p_gnt_req_r1: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (gnt_o & ~req_i) == '0);
  p_work_cons_r3: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (req_i != '0) |-> (gnt_o != '0));
  p_credit_first_r7: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (use_w && (celig != '0)) |-> ((gnt_o & cred_nz) != '0));
  p_sched_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    !$past(loop_end) |-> $stable(sched_q));
  p_slot_total_r5: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    valid_q |-> (sched_sum == (CNT_W+PTR_W+1)'(NPORT)));
  p_empty_sched_r9: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    !valid_q |-> (sched_q == '0));

  for (genvar g = 0; g < NPORT; g++) begin : g_chk
    p_active_slot_r5: assert property (@(posedge clk_i) disable iff (!rst_n_q)
      (loop_end && win_bus[g*SUM_W +: SUM_W] != '0) |=> (sched_q[g*CNT_W +: CNT_W] != '0));
  end
endmodule

// File: tb/demand_skip_arb_tb.sv
module demand_skip_arb_tb_top;
  localparam int NP = 4;
  localparam int BW = 4;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic [NP-1:0] req = '0;
  logic [NP*BW-1:0] bytes = '0;
  logic [NP-1:0] gnt;
  logic [NP*CW-1:0] sched;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  demand_skip_arb #(.NPORT(NP), .BYTE_W(BW), .HIST(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .req_i(req),
    .bytes_i(bytes), .gnt_o(gnt), .sched_o(sched)
  );

  // reference state
  int mslot = 0, mptr = 0, mvalid = 0;
  int mcred[NP], malloc[NP], macc[NP], mh0[NP], mwin[NP], ra[NP];
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // largest-remainder reference (R5, R6) computed from window totals mwin
  task automatic ref_alloc();
    int t, m;
    t = 0; m = 0;
    for (int i = 0; i < NP; i++) begin
      t += mwin[i];
      ra[i] = (mwin[i] != 0) ? 1 : 0;
      m += ra[i];
    end
    if (m != 0) begin
      for (int s = 0; s < NP - m; s++) begin
        int b; longint bv;
        b = -1; bv = 0;
        for (int i = 0; i < NP; i++) begin
          if (mwin[i] != 0) begin
            longint r;
            r = longint'(mwin[i]) * NP - longint'(ra[i]) * t;
            if (b < 0 || r > bv) begin b = i; bv = r; end
          end
        end
        ra[b]++;
      end
    end
  endtask

  function automatic logic [NP*CW-1:0] pack_alloc();
    logic [NP*CW-1:0] v;
    v = '0;
    for (int i = 0; i < NP; i++) v[i*CW +: CW] = CW'(malloc[i]);
    return v;
  endfunction

  task automatic cyc(input logic md, input logic [NP-1:0] rq, input logic [NP*BW-1:0] by);
    int pick, uw;
    logic [NP-1:0] ce, el, eg;
    string tag;
    @(negedge clk);
    mode = md; req = rq; bytes = by;
    #1;
    uw = (md && mvalid) ? 1 : 0;
    ce = '0;
    for (int i = 0; i < NP; i++) if (rq[i] && mcred[i] > 0) ce[i] = 1'b1;
    el = (uw != 0 && ce != '0) ? ce : rq;
    pick = -1;
    for (int off = 0; off < NP; off++) begin
      int p;
      p = (mptr + off) % NP;
      if (pick < 0 && el[p]) pick = p;
    end
    eg = '0;
    if (pick >= 0) eg[pick] = 1'b1;
    tag = (mvalid == 0) ? "R9 grant" : ((uw != 0) ? "R7 grant" : "R2 grant");
    chk(gnt == eg, tag, gnt, eg);
    chk(sched == pack_alloc(), "R8 schedule", sched, pack_alloc());
    if (mslot == 0) begin
      int sum;
      sum = 0;
      for (int i = 0; i < NP; i++) begin
        sum += malloc[i];
        if (mwin[i] != 0)
          chk(sched[i*CW +: CW] != 0, "R5 active port slot", sched[i*CW +: CW], 1);
        for (int j = 0; j < NP; j++)
          if (mwin[i] > mwin[j])
            chk(sched[i*CW +: CW] >= sched[j*CW +: CW], "R10 order",
                sched[i*CW +: CW], sched[j*CW +: CW]);
      end
      if (mvalid != 0) chk(sum == NP, "R5 slot total", sum, NP);
    end
    // advance reference to the next edge
    if (pick >= 0) begin
      mptr = (pick + 1) % NP;
      if (uw != 0 && mcred[pick] > 0) mcred[pick]--;
    end
    for (int i = 0; i < NP; i++) macc[i] += int'(by[i*BW +: BW]);
    if (mslot == NP - 1) begin
      int t;
      t = 0;
      for (int i = 0; i < NP; i++) begin
        mwin[i] = macc[i] + mh0[i];
        t += mwin[i];
      end
      ref_alloc();
      for (int i = 0; i < NP; i++) begin
        mh0[i] = macc[i]; macc[i] = 0;
        malloc[i] = ra[i]; mcred[i] = ra[i];
      end
      mvalid = (t != 0) ? 1 : 0;
      mslot = 0;
    end else begin
      mslot++;
    end
  endtask

  task automatic lfs();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] seq [8];
    logic [NP-1:0] quiet;
    logic md;
    for (int i = 0; i < NP; i++) begin
      mcred[i] = 0; malloc[i] = 0; macc[i] = 0; mh0[i] = 0; mwin[i] = 0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(gnt == '0, "R1 reset grant", gnt, 0);
    chk(sched == '0, "R9 reset schedule", sched, 0);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);

    // R2: ports 1 and 3 idle -> 0,2,0,2
    for (int k = 0; k < 8; k++) begin
      cyc(1'b0, 4'b0101, '0);
      seq[k] = gnt;
    end
    for (int k = 0; k < 8; k++)
      chk(seq[k] == ((k % 2 == 0) ? 4'b0001 : 4'b0100), "R2 skip order", seq[k],
          (k % 2 == 0) ? 4'b0001 : 4'b0100);

    // R6: port0 3 bytes/cycle, port1 1 byte/cycle -> slots 3,1,0,0
    for (int k = 0; k < NP; k++) cyc(1'b1, 4'b0000, 16'h0013);
    @(posedge clk); #1;
    chk(sched == 12'o0013, "R6 largest residual", sched, 12'o0013);
    // R3 / R7 under full demand with quota
    for (int k = 0; k < NP; k++) begin
      cyc(1'b1, 4'b1111, '0);
      chk(gnt != '0, "R3 work conserving", gnt, 1);
    end

    // R4: clear, then bytes only on the last cycle of a loop, then expiry
    for (int k = 0; k < 2 * NP; k++) cyc(1'b1, 4'b1010, '0);
    for (int k = 0; k < NP; k++) cyc(1'b1, 4'b1000, (k == NP - 1) ? 16'h5000 : 16'h0000);
    @(posedge clk); #1;
    chk(sched == 12'o4000, "R4 last cycle counted", sched, 12'o4000);
    for (int k = 0; k < NP; k++) cyc(1'b1, 4'b1001, '0);
    @(posedge clk); #1;
    chk(sched == 12'o4000, "R4 window keeps loop", sched, 12'o4000);
    for (int k = 0; k < NP; k++) cyc(1'b1, 4'b1001, '0);
    @(posedge clk); #1;
    chk(sched == '0, "R4 history expired", sched, 0);

    // ties: equal traffic on ports 1 and 2 -> 2,2 (R6 tie to lowest index, then equal)
    for (int k = 0; k < NP; k++) cyc(1'b1, 4'b0110, 16'h0220);
    @(posedge clk); #1;
    chk(sched == 12'o0220, "R6 equal shares", sched, 12'o0220);
    // three equal ports: extra slot to lowest index
    for (int k = 0; k < 2 * NP; k++) cyc(1'b0, 4'b0000, '0);
    for (int k = 0; k < NP; k++) cyc(1'b1, 4'b0111, 16'h0111);
    @(posedge clk); #1;
    chk(sched == 12'o0112, "R6 tie lowest index", sched, 12'o0112);

    // long pseudo-random sweep
    md = 1'b1; quiet = '0;
    for (int k = 0; k < 4000; k++) begin
      logic [NP*BW-1:0] by;
      logic [NP-1:0] rq;
      lfs();
      if (k % 64 == 0) begin md = lf[0]; quiet = lf[7:4]; end
      rq = lf[3:0] & ~quiet;
      lfs();
      by = lf;
      for (int i = 0; i < NP; i++) if (quiet[i]) by[i*BW +: BW] = '0;
      if (lf[15:13] == 3'b000) by = '0;
      cyc(md, rq, by);
    end

    // R9: no traffic history -> zero schedule, skip rotation in weighted mode
    for (int k = 0; k < 3 * NP; k++) begin
      lfs();
      cyc(1'b1, lf[3:0], '0);
    end
    @(posedge clk); #1;
    chk(sched == '0, "R9 fallback schedule", sched, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule